// File: doc/BRIEF.md
# Multiplexed Half-Word Burst Bus Master

This block moves data between a core and an external memory bus. The bus carries a 32-bit address. Its low 16 lines are shared between the address and a 16-bit data path. The core hands over one request at a time: a start address, a byte count from 1 to 16, a direction and, for writes, up to 128 bits of write data. The block then runs one bus transaction. That transaction is one address state followed by as many half-word data states as the byte count needs, up to eight.

In the address state the block drives the full address, strobes the latch-enable and address-status lines, and fixes the direction lines. During the data states it asserts the data-enable line. It inserts wait states for as long as the slave holds its ready input low. After each completed beat it steps the three word-address lines to the next half-word. Reads collect the returned half-words into one response word. At the end the block returns to idle and pulses a done flag for one cycle.

Top module: `mbus_master`

## Requirements
- R1: While reset is applied, `as_n`, `den_n` and `dtr` are high, and `ale` and `rsp_done` are low. After reset `req_ready` is high.
- R2: A request accepted at a clock edge (`req_valid` with `req_ready` high) makes the following cycle an address state. In that state `ale` is 1, `as_n` is 0, `den_n` is 1, `ad_oe` is 1, `ad_out` equals address bits 15:0, `a_hi` equals address bits 31:16 and `wa_out` equals address bits 3:1.
- R3: An address state lasts exactly one cycle. It is followed directly by data states, in which `den_n` is 0, `ale` is 0 and `as_n` is 1.
- R4: `req_len_m1` holds the byte count minus one. The number of completed beats is `req_len_m1/2 + 1` (integer division), which gives 1 to 8 beats.
- R5: A data state in which `rdy` is sampled low at the clock edge is repeated as a wait state. The beat does not advance and `wa_out` and `a_hi` hold their values. The data-state count equals the beat count plus the number of waits.
- R6: In beat k, `wa_out` equals (address bits 3:1 + k) modulo 8. `a_hi` stays constant for the whole transaction.
- R7: `wr` and `dtr` both equal the request direction (1 = write) from the address state through the last data state. `dtr` never changes while `den_n` is low.
- R8: For a write, `ad_oe` is 1 in data states and `ad_out` in beat k equals write-data bits [16k+15:16k]. For a read, `ad_oe` is 0 in data states.
- R9: For a read, the value of `ad_in` at the edge that completes beat k is stored in `rsp_rdata` bits [16k+15:16k]. All higher lanes read as zero.
- R10: The cycle after the edge that completes the last beat, `rsp_done` is 1 for exactly one cycle, `den_n` is high and `req_ready` is high.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_addr | input | 32 | Start byte address |
| req_len_m1 | input | 4 | Byte count minus one |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 128 | Write data, half-word k in bits [16k+15:16k] |
| rsp_rdata | output | 128 | Read data, valid with rsp_done |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| a_hi | output | 16 | Upper address lines |
| ad_out | output | 16 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared lines, incoming value |
| wa_out | output | 3 | Half-word address within the burst |
| ale | output | 1 | Address latch strobe, active high |
| as_n | output | 1 | Address state flag, active low |
| wr | output | 1 | Direction, 1 = write |
| den_n | output | 1 | Data state flag, active low |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| rdy | input | 1 | Slave ready, sampled in data states |

## Verification
A beat counter that slips shows up within one cycle: `wa_out` leaves the expected offset, and the write half-word on `ad_out` comes from the wrong lane. A sequencer that mishandles the final beat shows up at the end of the transaction: `rsp_done` arrives a beat early or late, or `den_n` stays low past the last ready. A wrong capture index only becomes visible at `rsp_done`, where whole read lanes are misplaced or missing. Random wait patterns make sure that waits on the first, middle and last beats are all covered.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bus_st_e;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int BEAT_W = 3,
  parameter int LEN_W  = BEAT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              rdy,
  output bus_st_e           st,
  output logic [BEAT_W-1:0] beat,
  output logic              beat_done,
  output logic              done
);
  // index of the final beat: bytes rounded up to half-words, minus one
  function automatic logic [BEAT_W-1:0] last_idx(input logic [LEN_W-1:0] n);
    return BEAT_W'(n >> 1);
  endfunction

  logic [BEAT_W-1:0] last_q;
  logic              final_beat;

  assign beat_done  = (st == ST_DATA) && rdy;
  assign final_beat = beat_done && (beat == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      beat   <= '0;
      last_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_ADDR;
          beat   <= '0;
          last_q <= last_idx(len_m1);
        end
        ST_ADDR: st <= ST_DATA;
        ST_DATA: begin
          if (final_beat) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else if (beat_done) begin
            beat <= beat + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbus_lanes.sv
module mbus_lanes #(
  parameter int DATA_W = 16,
  parameter int BEATS  = 8,
  parameter int BEAT_W = $clog2(BEATS),
  parameter int LINE_W = DATA_W * BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] wdata_in,
  input  logic              is_write,
  input  logic [BEAT_W-1:0] beat,
  input  logic              beat_done,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] wr_half,
  output logic [LINE_W-1:0] rdata
);
  logic [LINE_W-1:0] wdata_q;

  assign wr_half = wdata_q[int'(beat)*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      rdata   <= '0;
    end else if (start) begin
      wdata_q <= wdata_in;
      rdata   <= '0;
    end else if (beat_done && !is_write) begin
      rdata[int'(beat)*DATA_W +: DATA_W] <= ad_in;
    end
  end
endmodule

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int BEATS  = 8,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int LEN_W  = BEAT_W + 1,
  localparam int LINE_W = DATA_W * BEATS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len_m1,
  input  logic                 req_write,
  input  logic [LINE_W-1:0]    req_wdata,
  output logic [LINE_W-1:0]    rsp_rdata,
  output logic                 rsp_done,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]    ad_out,
  output logic                 ad_oe,
  input  logic [DATA_W-1:0]    ad_in,
  output logic [BEAT_W-1:0]    wa_out,
  output logic                 ale,
  output logic                 as_n,
  output logic                 wr,
  output logic                 den_n,
  output logic                 dtr,
  input  logic                 rdy
);
  bus_st_e           st;
  logic [BEAT_W-1:0] beat;
  logic              beat_done;
  logic              start;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, dtr_q;
  logic [DATA_W-1:0] wr_half;

  assign req_ready = (st == ST_IDLE);
  assign start     = req_valid && req_ready;

  mbus_seq #(.BEAT_W(BEAT_W), .LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len_m1(req_len_m1),
    .rdy(rdy), .st(st), .beat(beat), .beat_done(beat_done), .done(rsp_done)
  );

  mbus_lanes #(.DATA_W(DATA_W), .BEATS(BEATS)) lanes_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wdata_in(req_wdata),
    .is_write(wr_q), .beat(beat), .beat_done(beat_done), .ad_in(ad_in),
    .wr_half(wr_half), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      dtr_q  <= 1'b1;
    end else if (start) begin
      addr_q <= req_addr;
      wr_q   <= req_write;
      dtr_q  <= req_write;
    end
  end

  assign a_hi   = addr_q[ADDR_W-1:DATA_W];
  assign wa_out = addr_q[BEAT_W:1] + beat;
  assign ale    = (st == ST_ADDR);
  assign as_n   = (st != ST_ADDR);
  assign den_n  = (st != ST_DATA);
  assign ad_oe  = (st == ST_ADDR) || ((st == ST_DATA) && wr_q);
  assign ad_out = (st == ST_ADDR) ? addr_q[DATA_W-1:0] : wr_half;
  assign wr     = wr_q;
  assign dtr    = dtr_q;
endmodule

// File: rtl/mbus_master_chk.sv
module mbus_master_chk #(
  parameter int HI_W = 16,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              as_n,
  input logic              den_n,
  input logic              dtr,
  input logic              wr,
  input logic              rdy,
  input logic [BEAT_W-1:0] wa_out,
  input logic [HI_W-1:0]   a_hi,
  input logic              rsp_done,
  input logic              req_ready
);
  // R2
  ale_addr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!as_n && den_n));
  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && !den_n));
  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !rdy) |=> (!den_n && $stable(wa_out) && $stable(a_hi)));
  // R6
  wa_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && rdy) |=> (den_n || (wa_out == BEAT_W'($past(wa_out) + 1'b1))));
  // R7
  dtr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |=> (den_n || ($stable(dtr) && $stable(wr))));
  // R7
  dtr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> (dtr == wr));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (den_n && req_ready));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind mbus_master mbus_master_chk #(.HI_W(ADDR_W - DATA_W), .BEAT_W(BEAT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .as_n(as_n), .den_n(den_n),
  .dtr(dtr), .wr(wr), .rdy(rdy), .wa_out(wa_out), .a_hi(a_hi),
  .rsp_done(rsp_done), .req_ready(req_ready)
);

// File: tb/mbus_master_tb_top.sv
module mbus_master_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic [3:0]   req_len_m1 = '0;
  logic         req_write = 1'b0;
  logic [127:0] req_wdata = '0;
  logic [127:0] rsp_rdata;
  logic         rsp_done;
  logic [15:0]  a_hi, ad_out, ad_in;
  logic         ad_oe, ale, as_n, wr, den_n, dtr;
  logic [2:0]   wa_out;
  logic         rdy = 1'b0;
  int           errors = 0;
  int           checks = 0;

  assign ad_in = ad_in_q;
  logic [15:0] ad_in_q = '0;

  always #4 clk = ~clk;

  mbus_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .wa_out(wa_out), .ale(ale), .as_n(as_n), .wr(wr), .den_n(den_n),
    .dtr(dtr), .rdy(rdy)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [31:0] a, input int k);
    return a[15:0] ^ 16'(k * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic run_txn(input logic [31:0] a, input logic [3:0] lm, input bit w,
                         input logic [127:0] wd, input int wait_pct);
    int nb = int'(lm) / 2 + 1;
    int beat = 0;
    int waits = 0;
    int dcyc = 0;
    bit got_done = 1'b0;
    logic [127:0] exp_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len_m1 = lm; req_write = w; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // R2: address state
    chk(ale && !as_n && den_n && ad_oe, "R2 strobes", {ale, as_n, den_n, ad_oe}, 4'b1011);
    chk(ad_out == a[15:0] && a_hi == a[31:16] && wa_out == a[3:1], "R2 address",
        {a_hi, ad_out, wa_out}, {a[31:16], a[15:0], a[3:1]});
    chk(wr == w && dtr == w, "R7 direction in address state", {wr, dtr}, {w, w});
    for (int cyc = 0; cyc < 400; cyc++) begin
      bit r;
      @(negedge clk);
      if (rsp_done) begin got_done = 1'b1; break; end
      dcyc++;
      chk(!den_n && !ale && as_n, "R3 data state", {den_n, ale, as_n}, 3'b001);
      chk(wa_out == 3'(a[3:1] + beat) && a_hi == a[31:16], "R6 word address",
          {a_hi, wa_out}, {a[31:16], 3'(a[3:1] + beat)});
      chk(wr == w && dtr == w, "R7 direction held", {wr, dtr}, {w, w});
      chk(ad_oe == w, "R8 drive enable", ad_oe, w);
      if (w && beat < 8)
        chk(ad_out == wd[16*beat +: 16], "R8 write half-word", ad_out, wd[16*beat +: 16]);
      r = (int'($urandom % 100) >= wait_pct);
      rdy = r;
      ad_in_q = pat(a, beat);
      if (r) begin
        if (!w && beat < 8) exp_rd[16*beat +: 16] = pat(a, beat);
        beat++;
      end else begin
        waits++;
      end
    end
    rdy = 1'b0;
    chk(got_done, "R10 done seen", got_done, 1);
    chk(beat == nb, "R4 beat count", beat, nb);
    chk(dcyc == nb + waits, "R5 data cycles with waits", dcyc, nb + waits);
    if (!w) chk(rsp_rdata == exp_rd, "R9 read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_done && req_ready && den_n, "R10 one-cycle done",
        {rsp_done, req_ready, den_n}, 3'b011);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(as_n && den_n && dtr && !ale && !rsp_done, "R1 reset outputs",
        {as_n, den_n, dtr, ale, rsp_done}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && den_n, "R1 idle after reset", {req_ready, den_n}, 2'b11);
    // directed corners
    run_txn(32'h1234_5670, 4'd0,  1'b0, '0, 0);
    run_txn(32'hABCD_0000, 4'd15, 1'b1, 128'h0f0e0d0c_0b0a0908_07060504_03020100, 0);
    run_txn(32'h0000_000C, 4'd15, 1'b0, '0, 50);
    run_txn(32'hFFFF_FFFE, 4'd1,  1'b1, 128'h0000_BEEF, 70);
    run_txn(32'h8000_0004, 4'd2,  1'b0, '0, 90);
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
      run_txn($urandom, 4'($urandom), 1'($urandom), d, int'($urandom % 60));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule